// File: doc/BRIEF.md
# Stale-Value Weak-Order Memory Unit

This block models the memory side of a two-processor system that follows a weak ordering rule with instantaneous execution. Each processor owns a store queue, which holds its stores until they are written to a shared flat memory, and a stale-value list. The stale-value list holds address/value pairs that were overwritten in memory but that the processor may still legally observe. Each processor issues loads, stores and two kinds of fence through its own request port. A separate per-processor drain input asks the unit to move the oldest queued store into memory.

A load takes its value from the processor's own store queue first. Only when the address is absent there can the load take a stale value or the memory value. The choice is made by a stale-select bit and a slot index that come with the request, so a caller can steer the choice. One action happens per clock: either a processor request or a drain step. A round-robin arbiter picks it. A load returns its data one clock after it is granted.

Top module: `wmm_stale_mem`

## Requirements
- R1: After reset, memory reads as zero at every address, both store queues and both stale-value lists are empty, and no response is valid.
- R2: A granted store (op code 1) is appended to the issuing processor's store queue. A load (op code 0) whose address is in that queue returns the data of the youngest matching entry.
- R3: A granted drain step removes the oldest entry of that processor's store queue and writes its data to memory, so stores from one processor reach memory in issue order.
- R4: When a drain writes memory, the value that address held just before is appended as the youngest entry of every other processor's stale-value list. A processor whose store queue holds that address gets no entry.
- R5: A granted store removes every entry for its address from the issuing processor's stale-value list.
- R6: A load with stale-select set takes the stale-value list entry at the given slot (slot 0 is the oldest entry) when that slot is occupied, the address matches, and the store queue misses. It returns that entry's value and deletes all older entries for the same address. The chosen entry stays.
- R7: A load that returns the memory value deletes every entry for that address from the issuing processor's stale-value list.
- R8: A granted reconcile fence (op code 2) empties the issuing processor's stale-value list.
- R9: A commit fence (op code 3) is not granted while the issuing processor's store queue is non-empty.
- R10: A drain step that must insert into a full stale-value list (depth 8) is not performed. Memory and the queue stay unchanged until space exists. A store to a full store queue (depth 4) is not granted.
- R11: At most one request or drain step is granted per clock. Eligible requesters are served in round-robin order.
- R12: A granted load raises that processor's response-valid one clock later, with the load value on its data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPROC | Request present, one bit per processor |
| req_op | input | NPROC x 2 | Operation: 0 load, 1 store, 2 reconcile, 3 commit |
| req_addr | input | NPROC x AW | Word address |
| req_data | input | NPROC x DW | Store data |
| req_stale | input | NPROC | Load may take a stale value |
| req_slot | input | NPROC x log2(IB_DEPTH) | Stale-value list slot to take, 0 oldest |
| drain_req | input | NPROC | Ask for one drain step of that processor's store queue |
| req_grant | output | NPROC | Request accepted in this cycle |
| resp_valid | output | NPROC | Load data valid (one cycle after grant) |
| resp_data | output | NPROC x DW | Load data |

## Verification
The properties assume that a request counts only in the cycle it is granted. They also assume the operation code on a port is meaningful only while that grant is high, so they relate queue and list occupancies to grants one clock earlier. The stimulus offers a single request or a single drain step per step and drops it after one clock whether it was granted or not. This makes the grant order equal to the bench's own order. The only exception is one directed case in which both processors load at once to exercise the arbiter. Random addresses are confined to four words so that stale-value lists, queue hits and full-list stalls occur often.

// File: rtl/wmm_pkg.sv
package wmm_pkg;
    parameter int NPROC    = 2;
    parameter int AW       = 4;
    parameter int DW       = 8;
    parameter int SB_DEPTH = 4;
    parameter int IB_DEPTH = 8;

    localparam int MEM_WORDS = 1 << AW;
    localparam int SBCW      = $clog2(SB_DEPTH + 1);
    localparam int IBCW      = $clog2(IB_DEPTH + 1);
    localparam int SLW       = $clog2(IB_DEPTH);
    localparam int NREQ      = 2 * NPROC;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECON  = 2'd2,
        OP_COMMIT = 2'd3
    } mop_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ent_t;

    typedef ent_t [SB_DEPTH-1:0] sb_arr_t;
    typedef ent_t [IB_DEPTH-1:0] ib_arr_t;

    // true when one of the first n queue entries carries address a
    function automatic logic sb_holds(sb_arr_t e, logic [SBCW-1:0] n, logic [AW-1:0] a);
        logic h;
        h = 1'b0;
        for (int i = 0; i < SB_DEPTH; i++)
            if (SBCW'(i) < n && e[i].addr == a) h = 1'b1;
        return h;
    endfunction

    // youngest queue entry carrying address a (later index is younger)
    function automatic ent_t sb_newest(sb_arr_t e, logic [SBCW-1:0] n, logic [AW-1:0] a);
        ent_t r;
        r = '0;
        for (int i = 0; i < SB_DEPTH; i++)
            if (SBCW'(i) < n && e[i].addr == a) r = e[i];
        return r;
    endfunction
endpackage

// File: rtl/wmm_rr_arb.sv
module wmm_rr_arb #(
    parameter int N = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [PW-1:0] last;
    logic          found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int off = 1; off <= N; off++) begin
            if (!found && req[(int'(last) + off) % N]) begin
                gnt[(int'(last) + off) % N] = 1'b1;
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= PW'(N - 1);
        end else begin
            for (int i = 0; i < N; i++)
                if (gnt[i]) last <= PW'(i);
        end
    end
endmodule

// File: rtl/wmm_store_fifo.sv
module wmm_store_fifo
    import wmm_pkg::*;
#(
    parameter int DEPTH = SB_DEPTH,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  ent_t                 push_ent,
    input  logic                 pop,
    output ent_t [DEPTH-1:0]     ents,
    output logic [CW-1:0]        cnt
);
    // entry 0 is the oldest; push and pop are never granted together
    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
            cnt  <= '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == cnt) ents[i] <= push_ent;
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++)
                ents[i] <= ents[i+1];
            ents[DEPTH-1] <= '0;
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wmm_stale_buf.sv
module wmm_stale_buf
    import wmm_pkg::*;
#(
    parameter int DEPTH = IB_DEPTH,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 kill_en,
    input  logic [AW-1:0]        kill_addr,
    input  logic [CW-1:0]        kill_lim,
    input  logic                 ins_en,
    input  ent_t                 ins_ent,
    output ent_t [DEPTH-1:0]     ents,
    output logic [CW-1:0]        cnt
);
    ent_t [DEPTH-1:0] nxt;
    logic [CW-1:0]    n;

    // keep surviving entries in age order, packed from slot 0, then append
    always_comb begin
        nxt = '0;
        n   = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if ((CW'(j) < cnt) && !clr &&
                !(kill_en && ents[j].addr == kill_addr && CW'(j) < kill_lim)) begin
                for (int k = 0; k < DEPTH; k++)
                    if (CW'(k) == n) nxt[k] = ents[j];
                n = n + 1'b1;
            end
        end
        if (ins_en) begin
            for (int k = 0; k < DEPTH; k++)
                if (CW'(k) == n) nxt[k] = ins_ent;
            n = n + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
            cnt  <= '0;
        end else begin
            ents <= nxt;
            cnt  <= n;
        end
    end
endmodule

// File: rtl/wmm_stale_mem.sv
module wmm_stale_mem
    import wmm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPROC-1:0]            req_valid,
    input  logic [NPROC-1:0][1:0]       req_op,
    input  logic [NPROC-1:0][AW-1:0]    req_addr,
    input  logic [NPROC-1:0][DW-1:0]    req_data,
    input  logic [NPROC-1:0]            req_stale,
    input  logic [NPROC-1:0][SLW-1:0]   req_slot,
    input  logic [NPROC-1:0]            drain_req,
    output logic [NPROC-1:0]            req_grant,
    output logic [NPROC-1:0]            resp_valid,
    output logic [NPROC-1:0][DW-1:0]    resp_data
);
    sb_arr_t                     sb_ents [NPROC];
    logic [NPROC-1:0][SBCW-1:0]  sb_cnt;
    ib_arr_t                     ib_ents [NPROC];
    logic [NPROC-1:0][IBCW-1:0]  ib_cnt;
    logic [DW-1:0]               mem [MEM_WORDS];

    logic [NREQ-1:0]   elig;
    logic [NREQ-1:0]   gnt;
    mop_e              op        [NPROC];
    ent_t              head      [NPROC];
    logic              need_ins  [NPROC][NPROC];
    logic              blocked   [NPROC];
    logic              sb_hit    [NPROC];
    ent_t              sb_fwd    [NPROC];
    logic              slot_ok   [NPROC];
    logic [DW-1:0]     ld_val    [NPROC];
    logic              sb_push   [NPROC];
    logic              sb_pop    [NPROC];
    logic              ib_clr    [NPROC];
    logic              ib_kill   [NPROC];
    logic [IBCW-1:0]   ib_lim    [NPROC];
    logic              ib_ins    [NPROC];
    ent_t              ib_ins_ent[NPROC];

    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            op[p]   = mop_e'(req_op[p]);
            head[p] = sb_ents[p][0];
        end
        // drain side: who receives the overwritten value, and can they take it
        for (int p = 0; p < NPROC; p++)
            for (int q = 0; q < NPROC; q++)
                need_ins[p][q] = (p != q) && !sb_holds(sb_ents[q], sb_cnt[q], head[p].addr);
        for (int p = 0; p < NPROC; p++) begin
            blocked[p] = 1'b0;
            for (int q = 0; q < NPROC; q++)
                if (need_ins[p][q] && ib_cnt[q] == IBCW'(IB_DEPTH)) blocked[p] = 1'b1;
            elig[NPROC+p] = drain_req[p] && (sb_cnt[p] != '0) && !blocked[p];
            elig[p] = req_valid[p]
                   && !(op[p] == OP_STORE  && sb_cnt[p] == SBCW'(SB_DEPTH))
                   && !(op[p] == OP_COMMIT && sb_cnt[p] != '0);
        end
        // processor side: load value and buffer updates
        for (int p = 0; p < NPROC; p++) begin
            sb_hit[p]  = sb_holds(sb_ents[p], sb_cnt[p], req_addr[p]);
            sb_fwd[p]  = sb_newest(sb_ents[p], sb_cnt[p], req_addr[p]);
            slot_ok[p] = req_stale[p] && (IBCW'(req_slot[p]) < ib_cnt[p])
                      && (ib_ents[p][req_slot[p]].addr == req_addr[p]);
            if (sb_hit[p])       ld_val[p] = sb_fwd[p].data;
            else if (slot_ok[p]) ld_val[p] = ib_ents[p][req_slot[p]].data;
            else                 ld_val[p] = mem[req_addr[p]];
            sb_push[p] = gnt[p] && op[p] == OP_STORE;
            sb_pop[p]  = gnt[NPROC+p];
            ib_clr[p]  = gnt[p] && op[p] == OP_RECON;
            ib_kill[p] = gnt[p] && (op[p] == OP_STORE || (op[p] == OP_LOAD && !sb_hit[p]));
            ib_lim[p]  = (op[p] == OP_LOAD && slot_ok[p]) ? IBCW'(req_slot[p]) : IBCW'(IB_DEPTH);
            ib_ins[p]  = 1'b0;
            ib_ins_ent[p] = '0;
            for (int q = 0; q < NPROC; q++) begin
                if (gnt[NPROC+q] && need_ins[q][p]) begin
                    ib_ins[p]          = 1'b1;
                    ib_ins_ent[p].addr = head[q].addr;
                    ib_ins_ent[p].data = mem[head[q].addr];
                end
            end
        end
    end

    assign req_grant = gnt[NPROC-1:0];

    wmm_rr_arb #(.N(NREQ)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (elig),
        .gnt (gnt)
    );

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        ent_t push_ent;
        assign push_ent.addr = req_addr[p];
        assign push_ent.data = req_data[p];

        wmm_store_fifo #(.DEPTH(SB_DEPTH)) u_sb (
            .clk      (clk),
            .rst      (rst),
            .push     (sb_push[p]),
            .push_ent (push_ent),
            .pop      (sb_pop[p]),
            .ents     (sb_ents[p]),
            .cnt      (sb_cnt[p])
        );

        wmm_stale_buf #(.DEPTH(IB_DEPTH)) u_ib (
            .clk       (clk),
            .rst       (rst),
            .clr       (ib_clr[p]),
            .kill_en   (ib_kill[p]),
            .kill_addr (req_addr[p]),
            .kill_lim  (ib_lim[p]),
            .ins_en    (ib_ins[p]),
            .ins_ent   (ib_ins_ent[p]),
            .ents      (ib_ents[p]),
            .cnt       (ib_cnt[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
            resp_valid <= '0;
            resp_data  <= '0;
        end else begin
            for (int p = 0; p < NPROC; p++) begin
                resp_valid[p] <= gnt[p] && op[p] == OP_LOAD;
                if (gnt[p] && op[p] == OP_LOAD) resp_data[p] <= ld_val[p];
                if (gnt[NPROC+p]) mem[head[p].addr] <= head[p].data;
            end
        end
    end
endmodule

// File: rtl/wmm_stale_mem_sva.sv
module wmm_stale_mem_sva
    import wmm_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NREQ-1:0]             gnt,
    input logic [NPROC-1:0][1:0]       req_op,
    input logic [NPROC-1:0]            resp_valid,
    input logic [NPROC-1:0][SBCW-1:0]  sb_cnt,
    input logic [NPROC-1:0][IBCW-1:0]  ib_cnt
);
    assert_one_action_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    for (genvar p = 0; p < NPROC; p++) begin : g_chk
        assert_ib_bound_R10: assert property (@(posedge clk) disable iff (rst)
            ib_cnt[p] <= IBCW'(IB_DEPTH));

        assert_commit_empty_R9: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && req_op[p] == OP_COMMIT) |-> sb_cnt[p] == '0);

        assert_store_grows_R2: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && req_op[p] == OP_STORE) |=> sb_cnt[p] == $past(sb_cnt[p]) + 1'b1);

        assert_drain_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
            gnt[NPROC+p] |=> sb_cnt[p] == $past(sb_cnt[p]) - 1'b1);

        assert_recon_empty_R8: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && req_op[p] == OP_RECON) |=> ib_cnt[p] == '0);

        assert_load_resp_R12: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && req_op[p] == OP_LOAD) |=> resp_valid[p]);
    end
endmodule

bind wmm_stale_mem wmm_stale_mem_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .gnt        (gnt),
    .req_op     (req_op),
    .resp_valid (resp_valid),
    .sb_cnt     (sb_cnt),
    .ib_cnt     (ib_cnt)
);

// File: tb/wmm_stale_mem_tb.sv
module wmm_stale_mem_tb;
    import wmm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NPROC-1:0]           req_valid = '0;
    logic [NPROC-1:0][1:0]      req_op = '0;
    logic [NPROC-1:0][AW-1:0]   req_addr = '0;
    logic [NPROC-1:0][DW-1:0]   req_data = '0;
    logic [NPROC-1:0]           req_stale = '0;
    logic [NPROC-1:0][SLW-1:0]  req_slot = '0;
    logic [NPROC-1:0]           drain_req = '0;
    logic [NPROC-1:0]           req_grant;
    logic [NPROC-1:0]           resp_valid;
    logic [NPROC-1:0][DW-1:0]   resp_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // reference model state
    int mm  [MEM_WORDS];
    int sa  [NPROC][SB_DEPTH];
    int sd  [NPROC][SB_DEPTH];
    int sn  [NPROC];
    int ia  [NPROC][IB_DEPTH];
    int idt [NPROC][IB_DEPTH];
    int inn [NPROC];

    always #(CLK_PERIOD/2) clk = ~clk;

    wmm_stale_mem u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_stale(req_stale),
        .req_slot(req_slot), .drain_req(drain_req), .req_grant(req_grant),
        .resp_valid(resp_valid), .resp_data(resp_data)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    function automatic bit m_sb_has(int q, int a);
        for (int i = 0; i < sn[q]; i++) if (sa[q][i] == a) return 1;
        return 0;
    endfunction

    function automatic void m_ib_kill(int p, int a, int lim);
        int n = 0;
        for (int j = 0; j < inn[p]; j++) begin
            if (!(ia[p][j] == a && j < lim)) begin
                ia[p][n] = ia[p][j];
                idt[p][n] = idt[p][j];
                n++;
            end
        end
        inn[p] = n;
    endfunction

    function automatic bit m_drain_ok(int p);
        if (sn[p] == 0) return 0;
        for (int q = 0; q < NPROC; q++)
            if (q != p && !m_sb_has(q, sa[p][0]) && inn[q] == IB_DEPTH) return 0;
        return 1;
    endfunction

    function automatic void m_drain(int p);
        int a = sa[p][0];
        for (int q = 0; q < NPROC; q++) begin
            if (q != p && !m_sb_has(q, a)) begin
                ia[q][inn[q]] = a;
                idt[q][inn[q]] = mm[a];
                inn[q]++;
            end
        end
        mm[a] = sd[p][0];
        for (int i = 0; i < SB_DEPTH - 1; i++) begin
            sa[p][i] = sa[p][i+1];
            sd[p][i] = sd[p][i+1];
        end
        sn[p]--;
    endfunction

    function automatic int m_load(int p, int a, bit st, int sl);
        int v = -1;
        for (int i = 0; i < sn[p]; i++) if (sa[p][i] == a) v = sd[p][i];
        if (v >= 0) return v;
        if (st && sl < inn[p] && ia[p][sl] == a) begin
            v = idt[p][sl];
            m_ib_kill(p, a, sl);
            return v;
        end
        v = mm[a];
        m_ib_kill(p, a, IB_DEPTH);
        return v;
    endfunction

    // one request, offered for one clock; model updated when granted
    task automatic do_req(int p, int op, int a, int d, bit st, int sl, string tag, output int got);
        bit exp_g;
        bit g;
        int exp_v;
        exp_g = (op == 1) ? (sn[p] < SB_DEPTH) : (op == 3) ? (sn[p] == 0) : 1'b1;
        req_valid[p] = 1'b1;
        req_op[p]    = 2'(op);
        req_addr[p]  = AW'(a);
        req_data[p]  = DW'(d);
        req_stale[p] = st;
        req_slot[p]  = SLW'(sl);
        #1;
        g = req_grant[p];
        check(g == exp_g, {tag, " grant"}, int'(g), int'(exp_g));
        @(posedge clk);
        @(negedge clk);
        got = int'(resp_data[p]);
        if (exp_g) begin
            case (op)
                0: begin
                    exp_v = m_load(p, a, st, sl);
                    check(resp_valid[p] == 1'b1, {tag, " R12 resp_valid"}, int'(resp_valid[p]), 1);
                    check(got == exp_v, {tag, " load data"}, got, exp_v);
                end
                1: begin
                    sa[p][sn[p]] = a;
                    sd[p][sn[p]] = d;
                    sn[p]++;
                    m_ib_kill(p, a, IB_DEPTH);
                end
                2: inn[p] = 0;
                default: ;
            endcase
        end
        req_valid[p] = 1'b0;
    endtask

    task automatic do_drain(int p);
        bit ok;
        ok = m_drain_ok(p);
        drain_req[p] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        drain_req[p] = 1'b0;
        if (ok) m_drain(p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int got;
        int r;
        for (int i = 0; i < MEM_WORDS; i++) mm[i] = 0;
        for (int p = 0; p < NPROC; p++) begin
            sn[p] = 0;
            inn[p] = 0;
        end
        r = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(resp_valid == '0, "R1 resp_valid after reset", int'(resp_valid), 0);
        do_req(0, 0, 3, 0, 0, 0, "R1 mem zero", got);
        check(got == 0, "R1 literal zero", got, 0);
        do_req(1, 0, 7, 0, 1, 0, "R1 stale list empty", got);
        check(got == 0, "R1 stale empty literal", got, 0);

        // R2: forwarding from youngest queue entry
        do_req(0, 1, 1, 8'h11, 0, 0, "R2 store a", got);
        do_req(0, 1, 1, 8'h22, 0, 0, "R2 store b", got);
        do_req(0, 0, 1, 0, 0, 0, "R2 forward youngest", got);
        check(got == 8'h22, "R2 literal forward", got, 8'h22);
        do_req(1, 0, 1, 0, 0, 0, "R2 other proc sees memory", got);

        // R3/R4: drains in order, old values into other list
        do_drain(0);
        do_drain(0);
        do_req(1, 0, 1, 0, 1, 1, "R6 stale slot1", got);
        check(got == 8'h11, "R6 literal slot1", got, 8'h11);
        do_req(1, 0, 1, 0, 1, 0, "R6 older deleted, chosen kept", got);
        check(got == 8'h11, "R6 literal chosen kept", got, 8'h11);
        do_req(1, 0, 1, 0, 0, 0, "R3 memory holds last drained", got);
        check(got == 8'h22, "R3 literal memory", got, 8'h22);
        do_req(1, 0, 1, 0, 1, 0, "R7 memory read cleared list", got);
        check(got == 8'h22, "R7 literal", got, 8'h22);

        // R4 exception: other processor holds the address in its queue
        do_req(1, 1, 2, 8'h33, 0, 0, "R4 p1 store", got);
        do_req(0, 1, 2, 8'h44, 0, 0, "R4 p0 store", got);
        do_drain(0);
        do_req(1, 0, 2, 0, 0, 0, "R2 p1 forward over memory", got);
        do_drain(1);
        do_req(1, 0, 2, 0, 1, 0, "R4 no insert while queued", got);
        check(got == 8'h33, "R4 literal no insert", got, 8'h33);
        do_req(0, 0, 2, 0, 1, 0, "R4 old value inserted", got);
        check(got == 8'h44, "R4 literal inserted", got, 8'h44);

        // R5: own store clears matching stale entries
        do_req(0, 1, 2, 8'h55, 0, 0, "R5 store", got);
        do_drain(0);
        do_req(0, 0, 2, 0, 1, 0, "R5 stale entry removed", got);
        check(got == 8'h55, "R5 literal", got, 8'h55);

        // R8: reconcile empties list (p1 got the 0x33 entry from the last drain)
        do_req(1, 2, 0, 0, 0, 0, "R8 reconcile", got);
        do_req(1, 0, 2, 0, 1, 0, "R8 list empty", got);
        check(got == 8'h55, "R8 literal", got, 8'h55);

        // R9: commit stalls on a non-empty queue
        do_req(0, 1, 6, 8'h66, 0, 0, "R9 store", got);
        do_req(0, 3, 0, 0, 0, 0, "R9 commit stalled", got);
        do_drain(0);
        do_req(0, 3, 0, 0, 0, 0, "R9 commit after drain", got);

        // R10: full stale list blocks the drain
        do_req(1, 2, 0, 0, 0, 0, "R10 reconcile p1", got);
        for (int round = 0; round < 2; round++) begin
            for (int i = 0; i < SB_DEPTH; i++)
                do_req(0, 1, 8 + i, 8'h80 + 16 * round + i, 0, 0, "R10 fill store", got);
            do_req(0, 1, 12, 0, 0, 0, "R10 queue full store", got);
            for (int i = 0; i < SB_DEPTH; i++) do_drain(0);
        end
        do_req(0, 1, 12, 8'hAA, 0, 0, "R10 store blocked addr", got);
        do_drain(0);
        do_req(1, 0, 12, 0, 0, 0, "R10 drain held off", got);
        check(got == 0, "R10 literal memory unchanged", got, 0);
        do_req(1, 2, 0, 0, 0, 0, "R10 reconcile frees space", got);
        do_drain(0);
        do_req(1, 0, 12, 0, 0, 0, "R10 drain completes", got);
        check(got == 8'hAA, "R10 literal", got, 8'hAA);

        // R11: simultaneous loads served one per clock
        begin
            int first;
            int second;
            int ev;
            req_valid = 2'b11;
            req_op    = '0;
            req_stale = '0;
            req_addr[0] = AW'(9);
            req_addr[1] = AW'(12);
            #1;
            check($countones(req_grant) == 1, "R11 single grant", $countones(req_grant), 1);
            first  = req_grant[0] ? 0 : 1;
            second = 1 - first;
            @(posedge clk);
            @(negedge clk);
            ev = m_load(first, int'(req_addr[first]), 0, 0);
            check(int'(resp_data[first]) == ev, "R11 first load", int'(resp_data[first]), ev);
            req_valid[first] = 1'b0;
            #1;
            check(req_grant[second] == 1'b1, "R11 round robin next", int'(req_grant[second]), 1);
            @(posedge clk);
            @(negedge clk);
            ev = m_load(second, int'(req_addr[second]), 0, 0);
            check(int'(resp_data[second]) == ev, "R11 second load", int'(resp_data[second]), ev);
            req_valid = '0;
        end

        // constrained random mix on four addresses
        for (int it = 0; it < 600; it++) begin
            int kind;
            int p;
            int a;
            kind = int'($urandom % 7);
            p    = int'($urandom % 2);
            a    = int'($urandom % 4);
            case (kind)
                0, 1: do_req(p, 0, a, 0, 1'($urandom % 2), int'($urandom % IB_DEPTH), "R6 R7 random load", got);
                2:    do_req(p, 1, a, int'($urandom % 256), 0, 0, "R5 random store", got);
                3, 4: do_drain(p);
                5:    do_req(p, 2, 0, 0, 0, 0, "R8 random reconcile", got);
                default: do_req(p, 3, 0, 0, 0, 0, "R9 random commit", got);
            endcase
        end
        for (int a = 0; a < 4; a++)
            do_req(0, 0, a, 0, 0, 0, "R3 final memory", got);

        finish_run();
    end
endmodule